// File: doc/BRIEF.md
# Real-Time Clock Update-Cycle Controller

This block runs the once-per-second update cycle of a real-time clock. It holds two copies of the timekeeping bytes. The internal copy is the one the counters advance. The host-visible copy is the one that reads and writes reach. The bytes are seconds, minutes and hours, three alarm bytes, and an elapsed-seconds byte. A 1 Hz strobe starts each cycle. The block raises an update-in-progress status at once, counts a fixed number of base-rate pulses, then advances the internal counters. In that same clock it copies the advanced values to the host copy, unless the host has frozen its copy. An update-ended flag then tells the host that almost a full second is free for consistent reads.

While the host copy is frozen, the internal count keeps running, so time stays accurate while the host reads or sets the clock. Writes made while frozen go to both copies. Releasing the freeze brings the host copy back into line at the next transfer.

Top module: `rtc_update_ctrl`

## Requirements
- R1: After reset, all seven bytes in both copies read 0, and `uip` and `uf_flag` are 0.
- R2: A `sec_tick` pulse while `uip` is low sets `uip` on the next clock edge. A `sec_tick` while `uip` is high is ignored.
- R3: Once `uip` is high, the transfer happens on the clock edge that accepts the LEAD-th `base_tick` pulse (default 244). `uip` returns low on that same edge.
- R4: At a transfer the internal copy advances in binary. Seconds add 1, and a value of 59 or more becomes 0 and carries into minutes. Minutes do the same and carry into hours. Hours at 23 or more become 0. The elapsed byte adds 1, modulo 256. The alarm bytes are not changed.
- R5: If `freeze` is 0 on the transfer edge, the whole host copy takes the advanced internal values. On that edge the transfer overrides a host write made in the same cycle.
- R6: While `freeze` is 1, transfers leave the host copy unchanged, but the internal copy still advances.
- R7: After `freeze` returns to 0, the next transfer reloads the host copy with the running internal time.
- R8: A host write while `freeze` is 0 changes only the host copy. It reads back at once and is overwritten by the next transfer.
- R9: A host write while `freeze` is 1 goes into both copies. On a transfer edge the written byte overrides the advanced value of that byte.
- R10: `uf_flag` is set on every transfer edge and holds until a `uf_clr` pulse clears it. Setting wins over clearing in the same cycle.
- R11: Byte addresses are 0 seconds, 1 minutes, 2 hours, 3 alarm seconds, 4 alarm minutes, 5 alarm hours and 6 elapsed. Address 7 reads 0, and writes to it are ignored.
- R12: `host_rdata` shows the host-copy byte at `host_addr` combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick | input | 1 | Base-rate strobe used to time the lead window |
| sec_tick | input | 1 | 1 Hz strobe that starts an update cycle |
| freeze | input | 1 | Holds the host copy when 1 |
| host_we | input | 1 | Host write enable |
| host_addr | input | 3 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data from the host copy |
| uf_clr | input | 1 | Clears the update-ended flag |
| uip | output | 1 | Update in progress |
| uf_flag | output | 1 | Update-ended flag |

## Verification
The bench drives the clock through a 23:59:58 setting made while frozen. It then lets two transfers pass with the host copy held, and only after that releases the freeze. A design that stalled the internal count while frozen, or failed to carry hours to zero, would show the wrong time after the release. A second `sec_tick` during the lead window checks that the window is not restarted. A write made with the freeze off checks that the value is lost at the next transfer and not kept. Address 7 and the alarm bytes are probed so that a decoder slip or an alarm byte that wrongly advances shows up in the swept reads.

// File: rtl/rtc_update_ctrl.sv
module rtc_update_ctrl #(
  parameter int LEAD = 244
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       base_tick,
  input  logic       sec_tick,
  input  logic       freeze,
  input  logic       host_we,
  input  logic [2:0] host_addr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       uf_clr,
  output logic       uip,
  output logic       uf_flag
);
  localparam int CW = $clog2(LEAD + 1);
  localparam int NB = 7;

  logic [NB-1:0][7:0] int_q, usr_q, adv;
  logic [CW-1:0]      cnt_q;
  logic               xfer, wr_ok;

  assign xfer  = uip && base_tick && (cnt_q == CW'(LEAD - 1));
  assign wr_ok = host_we && (host_addr != 3'd7);
  assign host_rdata = (host_addr == 3'd7) ? 8'h00 : usr_q[host_addr];

  always_comb begin
    adv = int_q;
    if (int_q[0] >= 8'd59) begin
      adv[0] = 8'd0;
      if (int_q[1] >= 8'd59) begin
        adv[1] = 8'd0;
        adv[2] = (int_q[2] >= 8'd23) ? 8'd0 : int_q[2] + 8'd1;
      end else begin
        adv[1] = int_q[1] + 8'd1;
      end
    end else begin
      adv[0] = int_q[0] + 8'd1;
    end
    adv[6] = int_q[6] + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uip   <= 1'b0;
      cnt_q <= '0;
    end else if (xfer) begin
      uip   <= 1'b0;
      cnt_q <= '0;
    end else if (uip) begin
      if (base_tick) cnt_q <= cnt_q + 1'b1;
    end else if (sec_tick) begin
      uip   <= 1'b1;
      cnt_q <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      uf_flag <= 1'b0;
    else if (xfer)   uf_flag <= 1'b1;
    else if (uf_clr) uf_flag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_q <= '0;
    end else begin
      if (xfer) int_q <= adv;
      if (wr_ok && freeze) int_q[host_addr] <= host_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      usr_q <= '0;
    end else if (xfer && !freeze) begin
      usr_q <= adv;
    end else if (wr_ok) begin
      usr_q[host_addr] <= host_wdata;
    end
  end
endmodule

module rtc_update_ctrl_chk #(
  parameter int LEAD = 244
) (
  input logic        clk,
  input logic        rst_n,
  input logic        base_tick,
  input logic        sec_tick,
  input logic        freeze,
  input logic        host_we,
  input logic        uf_clr,
  input logic        uip,
  input logic        uf_flag,
  input logic [55:0] usr_q
);
  int unsigned win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                win <= 0;
    else if (uip && base_tick) win <= win + 1;
    else if (!uip)             win <= 0;
  end

  a_r2_uip_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(sec_tick));

  a_r3_lead_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> (win == LEAD));

  a_r10_flag_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> uf_flag);

  a_r10_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_flag && !uf_clr) |=> uf_flag);

  a_r6_frozen_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !host_we) |=> $stable(usr_q));

  a_r8_copy_moves_only_by_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_we && !(uip && base_tick)) |=> $stable(usr_q));
endmodule

bind rtc_update_ctrl rtc_update_ctrl_chk #(.LEAD(LEAD)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .sec_tick(sec_tick),
  .freeze(freeze), .host_we(host_we), .uf_clr(uf_clr), .uip(uip),
  .uf_flag(uf_flag), .usr_q(usr_q)
);

// File: tb/rtc_update_ctrl_test.sv
module rtc_update_ctrl_test;
  localparam int LEAD = 244;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       base_tick = 1'b0;
  logic       sec_tick = 1'b0;
  logic       freeze = 1'b0;
  logic       host_we = 1'b0;
  logic [2:0] host_addr = 3'd0;
  logic [7:0] host_wdata = 8'd0;
  logic       uf_clr = 1'b0;
  logic [7:0] host_rdata;
  logic       uip, uf_flag;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  rtc_update_ctrl #(.LEAD(LEAD)) uut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .sec_tick(sec_tick),
    .freeze(freeze), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .uf_clr(uf_clr),
    .uip(uip), .uf_flag(uf_flag)
  );

  always #5 clk = ~clk;

  always @(negedge clk) base_tick <= ~base_tick;

  // reference model
  int m_int[7];
  int m_usr[7];
  int m_adv[7];
  bit m_uip, m_uf;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_int[i]) begin m_int[i] = 0; m_usr[i] = 0; end
      m_uip = 0; m_uf = 0; m_cnt = 0;
    end else begin
      bit tr;
      tr = m_uip && base_tick && (m_cnt == LEAD - 1);
      foreach (m_adv[i]) m_adv[i] = m_int[i];
      if (m_int[0] >= 59) begin
        m_adv[0] = 0;
        if (m_int[1] >= 59) begin
          m_adv[1] = 0;
          m_adv[2] = (m_int[2] >= 23) ? 0 : m_int[2] + 1;
        end else m_adv[1] = m_int[1] + 1;
      end else m_adv[0] = m_int[0] + 1;
      m_adv[6] = (m_int[6] + 1) % 256;
      if (tr) foreach (m_int[i]) m_int[i] = m_adv[i];
      if (host_we && host_addr != 7 && freeze) m_int[host_addr] = host_wdata;
      if (tr && !freeze) foreach (m_usr[i]) m_usr[i] = m_adv[i];
      else if (host_we && host_addr != 7) m_usr[host_addr] = host_wdata;
      if (tr) m_uf = 1; else if (uf_clr) m_uf = 0;
      if (tr) begin m_uip = 0; m_cnt = 0; end
      else if (m_uip) begin if (base_tick) m_cnt++; end
      else if (sec_tick) begin m_uip = 1; m_cnt = 0; end
    end
  end

  // per-clock comparison, 3 ns after the edge
  always @(posedge clk) begin
    #3;
    if (rst_n && !done) begin
      int exp_rd;
      exp_rd = (host_addr == 7) ? 0 : m_usr[host_addr];
      checks++;
      if (uip !== m_uip) begin
        fails++; $display("FAIL R2 R3 uip actual=%0d expected=%0d", uip, m_uip);
      end
      checks++;
      if (uf_flag !== m_uf) begin
        fails++; $display("FAIL R10 uf_flag actual=%0d expected=%0d", uf_flag, m_uf);
      end
      checks++;
      if (host_rdata !== 8'(exp_rd)) begin
        fails++;
        $display("FAIL R4 R5 R12 rdata[%0d] actual=%0d expected=%0d", host_addr, host_rdata, exp_rd);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      host_we = 0; uf_clr = 0; sec_tick = 0;
      host_addr = host_addr + 3'd1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic expect_rd(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk);
    host_we = 0; host_addr = a;
    @(posedge clk); #4;
    checks++;
    if (host_rdata !== 8'(exp)) begin
      fails++; $display("FAIL %s addr=%0d actual=%0d expected=%0d", tag, a, host_rdata, exp);
    end
  endtask

  task automatic expect_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic one_second(input bit double_tick);
    @(negedge clk); sec_tick = 1;
    @(negedge clk); sec_tick = 0;
    idle(100);
    if (double_tick) begin
      @(negedge clk); sec_tick = 1;   // R2: ignored during window
      @(negedge clk); sec_tick = 0;
    end
    idle(2 * LEAD + 40);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    for (int a = 0; a < 7; a++) expect_rd(3'(a), 0, "R1 reset byte");
    expect_bit(uip, 1'b0, "R1 uip");
    expect_bit(uf_flag, 1'b0, "R1 uf_flag");

    one_second(1);
    expect_rd(3'd0, 1, "R4 R5 seconds");
    expect_rd(3'd6, 1, "R4 elapsed");
    expect_bit(uf_flag, 1'b1, "R10 flag set");
    @(negedge clk); uf_clr = 1;
    @(negedge clk); uf_clr = 0;
    @(posedge clk); #4;
    expect_bit(uf_flag, 1'b0, "R10 flag cleared");

    // R9: frozen writes reach both copies
    @(negedge clk); freeze = 1;
    wr(3'd2, 8'd23);
    wr(3'd1, 8'd59);
    wr(3'd0, 8'd58);
    wr(3'd3, 8'h30);
    expect_rd(3'd2, 23, "R9 hours written");
    one_second(0);
    expect_rd(3'd0, 58, "R6 frozen seconds");
    one_second(0);
    expect_rd(3'd2, 23, "R6 frozen hours");
    @(negedge clk); freeze = 0;
    one_second(0);
    expect_rd(3'd0, 1, "R7 R4 reload seconds");
    expect_rd(3'd1, 0, "R7 R4 minute rollover");
    expect_rd(3'd2, 0, "R7 R4 hour rollover");
    expect_rd(3'd3, 8'h30, "R4 R9 alarm kept");
    expect_rd(3'd6, 4, "R6 elapsed kept running");

    // R8: unfrozen write is temporary
    wr(3'd1, 8'd5);
    expect_rd(3'd1, 5, "R8 R12 immediate read");
    one_second(1);
    expect_rd(3'd1, 0, "R8 overwritten by transfer");
    expect_rd(3'd0, 2, "R5 seconds");

    // R11: address 7
    wr(3'd7, 8'hAA);
    expect_rd(3'd7, 0, "R11 addr7 reads 0");
    for (int a = 0; a < 7; a++) expect_rd(3'(a), m_usr[a], "R11 no alias");

    // R10: clear pressed continuously across a transfer
    @(negedge clk); sec_tick = 1; uf_clr = 1;
    @(negedge clk); sec_tick = 0;
    repeat (2 * LEAD + 20) @(negedge clk);
    uf_clr = 0;
    idle(20);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule